// File: doc/BRIEF.md
# Threshold Level Indicator with Alarm

The block watches a stream of 8-bit converter readings and shows each captured reading on a two-lamp display. It sorts every reading into one of three bands. A low reading lights the green lamp only. A middle reading lights both lamps, which reads as amber. A high reading lights the red lamp only and raises an alarm flag. The alarm is sticky: once set, it stays set until it is cleared on purpose.

A reading is taken only on a clock where the conversion-done strobe is high. Between strobes the block keeps classifying the last reading it took. The band result, together with the state of an alarm-clear request, passes through a fixed pipeline, so every change appears at the lamps exactly five rising edges after the input is sampled.

An alarm-clear request blanks both lamps and drops the alarm. When that request actually removes a latched alarm, the block emits a one-cycle acknowledge pulse. A push-button reset is asserted asynchronously and released through a two-flop synchronizer. While this reset is active it forces every output off.

Top module: `lvl_indicator`

## Requirements
- R1: A captured reading below 100 gives green on and red off, provided no alarm is latched.
- R2: A captured reading from 100 to 168 inclusive gives both red and green on, provided no alarm is latched.
- R3: A captured reading of 169 or more gives red on, green off and alarm on.
- R4: An output change caused by an input sampled on rising edge E appears on the outputs right after edge E+4 (the fifth rising edge counting E), and not earlier.
- R5: When the alarm-clear input is high on edge E, red, green and alarm are all low after edge E+4, whatever the band is.
- R6: A latched alarm stays high, and the display stays red only, for any later readings until a clear request (R5) or a reset (R8) reaches the outputs.
- R7: A reading is captured only on edges where conv_done_i is high. Otherwise the last captured reading keeps being shown, so a new value on sample_i with the strobe low does not change the outputs.
- R8: btn_rst_i takes effect asynchronously and is released after two rising edges. While it is in effect every output is low. After release, and before any reading has been captured, both lamps stay off.
- R9: alarm_clr_pulse_o is high for exactly one cycle, on the same edge where a clear request drops a latched alarm. A clear request that finds no alarm latched gives no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| btn_rst_i | input | 1 | Push-button reset, active high, asynchronous assert |
| conv_done_i | input | 1 | Conversion-done strobe; a reading is captured when high |
| sample_i | input | DATA_W (8) | Converter reading |
| alarm_clr_i | input | 1 | Alarm-clear request, active high |
| led_red_o | output | 1 | Red lamp |
| led_grn_o | output | 1 | Green lamp |
| alarm_o | output | 1 | Latched alarm flag |
| alarm_clr_pulse_o | output | 1 | One-cycle acknowledge when a latched alarm is cleared |

## Verification
The bench builds the block with its defaults: 8-bit readings, band limits at 100 and 169, and a latency of five edges. With these values every one of the 256 reading codes can be reached at random, and the four boundary codes 99, 100, 168 and 169 are driven on purpose. At five stages the pipeline is short enough that clear requests, strobe gaps and button presses often overlap in flight. This exposes cases such as a clear overtaking a high reading, or the alarm being raised again right after a clear from a held high reading.

// File: rtl/lvl_pkg.sv
package lvl_pkg;
    typedef enum logic [1:0] {
        BAND_NONE = 2'd0,
        BAND_LOW  = 2'd1,
        BAND_MID  = 2'd2,
        BAND_HIGH = 2'd3
    } band_e;

    typedef struct packed {
        band_e band;
        logic  clr;
    } stage_t;

    typedef struct packed {
        logic red;
        logic grn;
        logic alarm;
        logic pulse;
    } disp_t;
endpackage

// File: rtl/lvl_rst_sync.sv
module lvl_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic btn_i,
    output logic rst_o
);
    logic [STAGES-1:0] sync_q;

    always_ff @(posedge clk_i or posedge btn_i) begin
        if (btn_i) sync_q <= '1;
        else       sync_q <= {sync_q[STAGES-2:0], 1'b0};
    end

    assign rst_o = sync_q[STAGES-1];
endmodule

// File: rtl/lvl_capture.sv
module lvl_capture
    import lvl_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int MID_LO  = 100,
    parameter int HIGH_LO = 169
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              strobe_i,
    input  logic [DATA_W-1:0] sample_i,
    input  logic              clr_i,
    output stage_t            head_o
);
    localparam logic [DATA_W-1:0] MID_EDGE  = DATA_W'(MID_LO);
    localparam logic [DATA_W-1:0] HIGH_EDGE = DATA_W'(HIGH_LO);

    stage_t head_d, head_q;

    always_comb begin
        head_d     = head_q;
        head_d.clr = clr_i;
        if (strobe_i) begin
            if (sample_i < MID_EDGE)       head_d.band = BAND_LOW;
            else if (sample_i < HIGH_EDGE) head_d.band = BAND_MID;
            else                           head_d.band = BAND_HIGH;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) head_q <= '0;
        else       head_q <= head_d;
    end

    assign head_o = head_q;
endmodule

// File: rtl/lvl_delay.sv
module lvl_delay
    import lvl_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic   clk_i,
    input  logic   rst_i,
    input  stage_t in_i,
    output stage_t out_o
);
    generate
        if (DEPTH == 0) begin : g_bypass
            assign out_o = in_i;
        end else begin : g_chain
            stage_t chain_d [DEPTH];
            stage_t chain_q [DEPTH];

            always_comb begin
                chain_d[0] = in_i;
                for (int i = 1; i < DEPTH; i++) chain_d[i] = chain_q[i-1];
            end

            always_ff @(posedge clk_i) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (rst_i) chain_q[i] <= '0;
                    else       chain_q[i] <= chain_d[i];
                end
            end

            assign out_o = chain_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/lvl_display.sv
module lvl_display
    import lvl_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  stage_t tail_i,
    output disp_t  disp_o
);
    disp_t disp_d, disp_q;

    always_comb begin
        disp_d = disp_q;
        if (tail_i.clr) begin
            disp_d       = '0;
            disp_d.pulse = disp_q.alarm;
        end else begin
            disp_d.pulse = 1'b0;
            disp_d.alarm = disp_q.alarm | (tail_i.band == BAND_HIGH);
            if (disp_d.alarm) begin
                disp_d.red = 1'b1;
                disp_d.grn = 1'b0;
            end else begin
                unique case (tail_i.band)
                    BAND_LOW:  begin disp_d.red = 1'b0; disp_d.grn = 1'b1; end
                    BAND_MID:  begin disp_d.red = 1'b1; disp_d.grn = 1'b1; end
                    default:   begin disp_d.red = 1'b0; disp_d.grn = 1'b0; end
                endcase
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) disp_q <= '0;
        else       disp_q <= disp_d;
    end

    assign disp_o = disp_q;
endmodule

// File: rtl/lvl_indicator.sv
module lvl_indicator
    import lvl_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int MID_LO   = 100,
    parameter int HIGH_LO  = 169,
    parameter int LATENCY  = 5,
    parameter int SYNC_LEN = 2
) (
    input  logic              clk_i,
    input  logic              btn_rst_i,
    input  logic              conv_done_i,
    input  logic [DATA_W-1:0] sample_i,
    input  logic              alarm_clr_i,
    output logic              led_red_o,
    output logic              led_grn_o,
    output logic              alarm_o,
    output logic              alarm_clr_pulse_o
);
    localparam int MID_STAGES = LATENCY - 2;

    logic   rst_s;
    stage_t head;
    stage_t tail;
    disp_t  disp;

    lvl_rst_sync #(.STAGES(SYNC_LEN)) i_sync (
        .clk_i (clk_i),
        .btn_i (btn_rst_i),
        .rst_o (rst_s)
    );

    lvl_capture #(.DATA_W(DATA_W), .MID_LO(MID_LO), .HIGH_LO(HIGH_LO)) i_capture (
        .clk_i    (clk_i),
        .rst_i    (rst_s),
        .strobe_i (conv_done_i),
        .sample_i (sample_i),
        .clr_i    (alarm_clr_i),
        .head_o   (head)
    );

    lvl_delay #(.DEPTH(MID_STAGES)) i_delay (
        .clk_i (clk_i),
        .rst_i (rst_s),
        .in_i  (head),
        .out_o (tail)
    );

    lvl_display i_display (
        .clk_i  (clk_i),
        .rst_i  (rst_s),
        .tail_i (tail),
        .disp_o (disp)
    );

    assign led_red_o         = disp.red;
    assign led_grn_o         = disp.grn;
    assign alarm_o           = disp.alarm;
    assign alarm_clr_pulse_o = disp.pulse;
endmodule

// File: rtl/lvl_indicator_chk.sv
module lvl_indicator_chk
    import lvl_pkg::*;
(
    input logic   clk,
    input logic   rst_s,
    input logic   conv_done,
    input stage_t head,
    input stage_t tail,
    input logic   red,
    input logic   grn,
    input logic   alarm,
    input logic   pulse
);
    // R1
    low_band_chk: assert property (@(posedge clk) disable iff (rst_s)
        (tail.band == BAND_LOW && !tail.clr && !alarm) |=> (grn && !red));

    // R2
    mid_band_chk: assert property (@(posedge clk) disable iff (rst_s)
        (tail.band == BAND_MID && !tail.clr && !alarm) |=> (grn && red));

    // R3
    high_band_chk: assert property (@(posedge clk) disable iff (rst_s)
        (tail.band == BAND_HIGH && !tail.clr) |=> (red && !grn && alarm));

    // R5
    clear_blank_chk: assert property (@(posedge clk) disable iff (rst_s)
        tail.clr |=> (!red && !grn && !alarm));

    // R6
    alarm_hold_chk: assert property (@(posedge clk) disable iff (rst_s)
        (alarm && !tail.clr) |=> (alarm && red && !grn));

    // R7
    hold_sample_chk: assert property (@(posedge clk) disable iff (rst_s)
        !conv_done |=> $stable(head.band));

    // R8
    reset_off_chk: assert property (@(posedge clk)
        rst_s |=> (!red && !grn && !alarm && !pulse));

    // R9
    pulse_chk: assert property (@(posedge clk) disable iff (rst_s)
        pulse |-> (!alarm && $past(alarm)));
endmodule

bind lvl_indicator lvl_indicator_chk i_chk (
    .clk       (clk_i),
    .rst_s     (rst_s),
    .conv_done (conv_done_i),
    .head      (head),
    .tail      (tail),
    .red       (led_red_o),
    .grn       (led_grn_o),
    .alarm     (alarm_o),
    .pulse     (alarm_clr_pulse_o)
);

// File: tb/test_lvl_indicator.sv
module test_lvl_indicator;
    logic       clk = 1'b0;
    logic       btn = 1'b1;
    logic       strobe = 1'b0;
    logic [7:0] sample = 8'd0;
    logic       clr = 1'b0;
    logic       red, grn, alarm, pulse;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    bit en    = 0;
    string phase = "";

    // model state
    bit [1:0] m_sync = 2'b11;
    int       st_band [4];
    bit       st_clr  [4];
    bit       m_red, m_grn, m_alarm, m_pulse;
    string    m_tag = "R8";

    always #10 clk = ~clk;

    lvl_indicator i_lvl_indicator (
        .clk_i             (clk),
        .btn_rst_i         (btn),
        .conv_done_i       (strobe),
        .sample_i          (sample),
        .alarm_clr_i       (clr),
        .led_red_o         (red),
        .led_grn_o         (grn),
        .alarm_o           (alarm),
        .alarm_clr_pulse_o (pulse)
    );

    function automatic int cls(input logic [7:0] v);
        if (v < 8'd100)      return 1;
        else if (v < 8'd169) return 2;
        else                 return 3;
    endfunction

    task automatic model_step();
        bit old_rst = m_sync[1];
        if (old_rst) begin
            for (int i = 0; i < 4; i++) begin st_band[i] = 0; st_clr[i] = 0; end
            m_red = 0; m_grn = 0; m_alarm = 0; m_pulse = 0; m_tag = "R8";
        end else begin
            int tb = st_band[3];
            bit tc = st_clr[3];
            if (tc) begin
                m_tag = m_alarm ? "R9" : "R5";
                m_pulse = m_alarm; m_alarm = 0; m_red = 0; m_grn = 0;
            end else begin
                m_pulse = 0;
                if (m_alarm) m_tag = "R6";
                else if (tb == 3) m_tag = "R3";
                else if (tb == 2) m_tag = "R2";
                else if (tb == 1) m_tag = "R1";
                else m_tag = "R8";
                if (tb == 3) m_alarm = 1;
                if (m_alarm) begin m_red = 1; m_grn = 0; end
                else begin
                    m_red = (tb == 2);
                    m_grn = (tb == 1) || (tb == 2);
                end
            end
            for (int i = 3; i > 0; i--) begin st_band[i] = st_band[i-1]; st_clr[i] = st_clr[i-1]; end
            if (strobe) st_band[0] = cls(sample);
            st_clr[0] = clr;
        end
        m_sync = btn ? 2'b11 : {m_sync[0], 1'b0};
    endtask

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: outputs red/grn/alarm/pulse actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
        model_step();
        if (en) check(phase != "" ? phase : m_tag, {red, grn, alarm, pulse},
                      {m_red, m_grn, m_alarm, m_pulse});
    endtask

    task automatic press_btn(input int n);
        btn = 1'b1; m_sync = 2'b11;
        repeat (n) cycle();
        btn = 1'b0;
    endtask

    task automatic show(input logic [7:0] v, input int n);
        strobe = 1'b1; sample = v;
        cycle();
        strobe = 1'b0;
        repeat (n - 1) cycle();
    endtask

    initial begin
        repeat (2) cycle();
        en = 1;
        phase = "R8";
        repeat (3) cycle();
        btn = 1'b0;
        repeat (4) cycle();
        phase = "";

        // R4: nothing moves before the fifth edge, green appears on it
        strobe = 1'b1; sample = 8'd50;
        cycle();
        strobe = 1'b0;
        repeat (3) begin cycle(); check("R4", {red, grn}, 2'b00); end
        cycle(); check("R4", {red, grn}, 2'b01);

        show(8'd0,   6); check("R1", {red, grn, alarm}, 3'b010);
        show(8'd99,  6); check("R1", {red, grn, alarm}, 3'b010);
        show(8'd100, 6); check("R2", {red, grn, alarm}, 3'b110);
        show(8'd168, 6); check("R2", {red, grn, alarm}, 3'b110);

        // R7: new sample with strobe low is ignored
        sample = 8'd250;
        repeat (7) cycle();
        check("R7", {red, grn, alarm}, 3'b110);

        // R5 with no alarm latched: blank and no pulse (R9)
        clr = 1'b1; cycle(); clr = 1'b0;
        repeat (4) cycle();
        check("R5", {red, grn, alarm, pulse}, 4'b0000);
        cycle(); check("R9", pulse, 1'b0);

        show(8'd169, 6); check("R3", {red, grn, alarm}, 3'b101);
        show(8'd10,  7); check("R6", {red, grn, alarm}, 3'b101);
        show(8'd255, 6); check("R3", {red, grn, alarm}, 3'b101);
        show(8'd120, 6); check("R6", {red, grn, alarm}, 3'b101);

        // R9: clear a latched alarm; pulse once
        clr = 1'b1; cycle(); cycle(); clr = 1'b0;
        repeat (3) cycle();
        check("R9", {alarm, pulse}, 2'b01);
        cycle(); check("R9", {alarm, pulse}, 2'b00);
        check("R5", {red, grn}, 2'b00);

        // R8: mid-run button press
        show(8'd200, 6);
        press_btn(3);
        check("R8", {red, grn, alarm, pulse}, 4'b0000);
        repeat (6) cycle();
        check("R8", {red, grn}, 2'b00);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            int r = $urandom_range(0, 999);
            sample = 8'($urandom_range(0, 255));
            strobe = ($urandom_range(0, 1) == 1);
            clr    = ($urandom_range(0, 19) == 0);
            if (r < 4) press_btn(3);
            else cycle();
        end
        clr = 1'b0; strobe = 1'b0;
        repeat (8) cycle();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end

    initial begin
        #4000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule